// File: doc/BRIEF.md
# Windowed Integer Register File

This block is an integer register file for a processor that allocates a fresh register window on each subroutine entry. Software addresses 32 logical registers through a 5-bit number. Eight of them are globals shared by every window. The other 24 belong to the current window: eight outgoing-argument registers ("outs"), eight private scratch registers ("locals") and eight incoming-argument registers ("ins"). The outs of one window are the same storage as the ins of the next window. A caller can therefore leave arguments in its outs, and the callee finds them in its ins after a save, with no data copied.

A save command advances the current window pointer. A restore command moves it back. Three counters track the window budget: free windows (`cansave`), windows that can be returned to (`canrestore`), and windows owned by another context (`otherwin`). If a save or restore cannot be honoured, the block leaves its state untouched and raises a one-cycle spill or fill flag, which the trap logic around it acts on. A privileged load port writes the three counters at once. The block accepts the load only if the counters keep their fixed budget.

The block has two combinational read ports and one write port. A write is forwarded to a read of the same physical register in the same cycle.

Top module: `winreg_file`

## Requirements
- R1: Logical numbers 0-7 (bits [4:3] = 00) select globals, which are the same storage in every window. 8-15 (01) select outs, 16-23 (10) select locals and 24-31 (11) select ins of the current window.
- R2: Logical register 0 reads as zero on both read ports, and a write to it has no effect, even in the write's own cycle.
- R3: Out register 8+k of window w is the same storage as in register 24+k of window (w+1) mod NWIN, including the wrap from window NWIN-1 to window 0.
- R4: Each window has eight private locals: a local written in one window is not changed by writes to the same local number in another window.
- R5: A save with `cansave` non-zero increments `cwp` modulo NWIN, decrements `cansave` and increments `canrestore`, visible after the next rising edge.
- R6: A restore with `canrestore` non-zero decrements `cwp` modulo NWIN (0 wraps to NWIN-1), increments `cansave` and decrements `canrestore`.
- R7: A save while `cansave` is 0 pulses `spill` high for exactly the cycle after the request and leaves `cwp` and all counters unchanged.
- R8: A restore while `canrestore` is 0 pulses `fill` high for exactly the cycle after the request and leaves `cwp` and all counters unchanged.
- R9: `cansave + canrestore + otherwin` always equals NWIN-2. A counter load whose three values do not sum to NWIN-2 is dropped, and leaves every counter and `cwp` unchanged.
- R10: A counter load with a valid sum replaces all three counters at the next edge, does not move `cwp`, and takes priority over a save or restore in the same cycle.
- R11: When save and restore are requested together, the save is performed and the restore is ignored.
- R12: A write in a cycle is returned on any read port that addresses the same physical register in that cycle.
- R13: After reset, `cwp` = 0, `cansave` = NWIN-2, `canrestore` = 0, `otherwin` = 0, and `spill` and `fill` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_a_idx | input | 5 | Logical register number, read port A |
| rd_a_data | output | XLEN | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Logical register number, read port B |
| rd_b_data | output | XLEN | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical register number for the write |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Request to allocate the next window |
| restore_req | input | 1 | Request to return to the previous window |
| ld_en | input | 1 | Privileged counter load strobe |
| ld_cansave | input | CNT_W | Value to load into cansave |
| ld_canrestore | input | CNT_W | Value to load into canrestore |
| ld_otherwin | input | CNT_W | Value to load into otherwin |
| cwp | output | CWP_W | Current window pointer |
| cansave | output | CNT_W | Windows available for save |
| canrestore | output | CNT_W | Windows available for restore |
| otherwin | output | CNT_W | Windows held by another context |
| spill | output | 1 | One-cycle pulse: save refused (overflow) |
| fill | output | 1 | One-cycle pulse: restore refused (underflow) |

## Verification
Assertions check on every cycle that the counter budget holds. They also check the exact counter and pointer steps of accepted saves and restores, the frozen state and single flag on a refused command, that a load with a bad sum changes nothing, that register 0 reads zero on both ports, and that a write is forwarded to a read of the same register. Only the bench scenarios can show the storage-level behaviour: that globals survive a window change, that outs reappear as the next window's ins (including the wrap from the last window to window 0), and that locals stay private to each window. Those results depend on values written several commands earlier.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  localparam int unsigned LIDX_W      = 5;
  localparam int unsigned NUM_GLOBALS = 8;
  localparam int unsigned BANK_REGS   = 16;

  // Register class is decoded from logical index bits [4:3].
  typedef enum logic [1:0] {
    CLS_GLOBAL = 2'b00,
    CLS_OUT    = 2'b01,
    CLS_LOCAL  = 2'b10,
    CLS_IN     = 2'b11
  } reg_cls_e;

  // Resolved command, load first, then save, then restore.
  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_LOAD,
    CMD_SAVE,
    CMD_RESTORE
  } win_cmd_e;

endpackage

// File: rtl/winreg_rst_sync.sv
module winreg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/winreg_map.sv
module winreg_map #(
  parameter int unsigned NWIN   = 8,
  parameter int unsigned CWP_W  = 3,
  parameter int unsigned PIDX_W = 8
) (
  input  logic [CWP_W-1:0]           cwp_i,
  input  logic [wrf_pkg::LIDX_W-1:0] lidx_i,
  output logic [PIDX_W-1:0]          pidx_o
);
  import wrf_pkg::*;

  // Physical layout: globals at 0..7, then one 16-entry bank per window:
  // bank offset 0..7 = locals, 8..15 = ins. Outs live in the next bank's ins.
  logic [CWP_W-1:0] bank;
  logic             upper;
  logic             is_glob;
  reg_cls_e         cls;

  assign cls = reg_cls_e'(lidx_i[4:3]);

  always_comb begin
    bank    = cwp_i;
    upper   = 1'b0;
    is_glob = 1'b0;
    unique case (cls)
      CLS_GLOBAL: is_glob = 1'b1;
      CLS_OUT: begin
        bank  = cwp_i + 1'b1;   // wraps modulo NWIN (power of two)
        upper = 1'b1;
      end
      CLS_LOCAL: upper = 1'b0;
      CLS_IN:    upper = 1'b1;
      default:   is_glob = 1'b1;
    endcase
    if (is_glob) begin
      pidx_o = PIDX_W'(lidx_i[2:0]);
    end else begin
      pidx_o = PIDX_W'(NUM_GLOBALS) + (PIDX_W'(bank) << 4)
             + PIDX_W'({upper, lidx_i[2:0]});
    end
  end

endmodule

// File: rtl/winreg_array.sv
module winreg_array #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned NPHYS  = 136,
  parameter int unsigned PIDX_W = 8,
  parameter int unsigned NRD    = 2
) (
  input  logic                      clk,
  input  logic                      wr_en_i,
  input  logic [PIDX_W-1:0]         wr_pidx_i,
  input  logic [XLEN-1:0]           wr_data_i,
  input  logic [NRD-1:0][PIDX_W-1:0] rd_pidx_i,
  output logic [NRD-1:0][XLEN-1:0]   rd_data_o
);

  logic [XLEN-1:0] mem_q [NPHYS];
  logic            wr_ce;

  // Entry 0 is the hard-wired zero; it is never written.
  assign wr_ce = wr_en_i && (wr_pidx_i != '0);

  always_ff @(posedge clk) begin
    if (wr_ce) begin
      mem_q[wr_pidx_i] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rd_pidx_i[p] == '0) begin
        rd_data_o[p] = '0;
      end else if (wr_ce && (wr_pidx_i == rd_pidx_i[p])) begin
        rd_data_o[p] = wr_data_i;
      end else begin
        rd_data_o[p] = mem_q[rd_pidx_i[p]];
      end
    end
  end

endmodule

// File: rtl/winreg_ctrl.sv
module winreg_ctrl #(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned CWP_W = 3,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic             ld_en_i,
  input  logic [CNT_W-1:0] ld_cs_i,
  input  logic [CNT_W-1:0] ld_cr_i,
  input  logic [CNT_W-1:0] ld_ow_i,
  output logic [CWP_W-1:0] cwp_o,
  output logic [CNT_W-1:0] cs_o,
  output logic [CNT_W-1:0] cr_o,
  output logic [CNT_W-1:0] ow_o,
  output logic             spill_o,
  output logic             fill_o
);
  import wrf_pkg::*;

  localparam int unsigned       SUM_W  = CNT_W + 2;
  localparam logic [SUM_W-1:0]  BUDGET = SUM_W'(NWIN - 2);

  logic [CWP_W-1:0] cwp_q, cwp_d;
  logic [CNT_W-1:0] cs_q, cs_d, cr_q, cr_d, ow_q, ow_d;
  logic             spill_q, spill_d, fill_q, fill_d;
  logic             state_ce;
  logic             ld_ok;
  win_cmd_e         cmd;

  assign ld_ok = (SUM_W'(ld_cs_i) + SUM_W'(ld_cr_i) + SUM_W'(ld_ow_i)) == BUDGET;

  // Next-state logic
  always_comb begin
    if (ld_en_i)        cmd = CMD_LOAD;
    else if (save_i)    cmd = CMD_SAVE;
    else if (restore_i) cmd = CMD_RESTORE;
    else                cmd = CMD_NONE;

    cwp_d   = cwp_q;
    cs_d    = cs_q;
    cr_d    = cr_q;
    ow_d    = ow_q;
    spill_d = 1'b0;
    fill_d  = 1'b0;

    unique case (cmd)
      CMD_LOAD: begin
        if (ld_ok) begin
          cs_d = ld_cs_i;
          cr_d = ld_cr_i;
          ow_d = ld_ow_i;
        end
      end
      CMD_SAVE: begin
        if (cs_q == '0) begin
          spill_d = 1'b1;
        end else begin
          cwp_d = cwp_q + 1'b1;
          cs_d  = cs_q - 1'b1;
          cr_d  = cr_q + 1'b1;
        end
      end
      CMD_RESTORE: begin
        if (cr_q == '0) begin
          fill_d = 1'b1;
        end else begin
          cwp_d = cwp_q - 1'b1;
          cs_d  = cs_q + 1'b1;
          cr_d  = cr_q - 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign state_ce = (cmd != CMD_NONE);

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q   <= '0;
      cs_q    <= CNT_W'(NWIN - 2);
      cr_q    <= '0;
      ow_q    <= '0;
      spill_q <= 1'b0;
      fill_q  <= 1'b0;
    end else begin
      if (state_ce) begin
        cwp_q <= cwp_d;
        cs_q  <= cs_d;
        cr_q  <= cr_d;
        ow_q  <= ow_d;
      end
      spill_q <= spill_d;
      fill_q  <= fill_d;
    end
  end

  assign cwp_o   = cwp_q;
  assign cs_o    = cs_q;
  assign cr_o    = cr_q;
  assign ow_o    = ow_q;
  assign spill_o = spill_q;
  assign fill_o  = fill_q;

  // Budget invariant
  p_budget_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (SUM_W'(cs_q) + SUM_W'(cr_q) + SUM_W'(ow_q)) == BUDGET);

  p_save_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en_i && save_i && cs_q != '0) |=>
      (cwp_q == CWP_W'($past(cwp_q) + 1'b1)) && (cs_q == CNT_W'($past(cs_q) - 1'b1))
      && (cr_q == CNT_W'($past(cr_q) + 1'b1)) && !spill_q);

  p_restore_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en_i && !save_i && restore_i && cr_q != '0) |=>
      (cwp_q == CWP_W'($past(cwp_q) - 1'b1)) && (cr_q == CNT_W'($past(cr_q) - 1'b1))
      && (cs_q == CNT_W'($past(cs_q) + 1'b1)) && !fill_q);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en_i && save_i && cs_q == '0) |=>
      spill_q && $stable(cwp_q) && $stable(cs_q) && $stable(cr_q) && $stable(ow_q));

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en_i && !save_i && restore_i && cr_q == '0) |=>
      fill_q && $stable(cwp_q) && $stable(cs_q) && $stable(cr_q) && $stable(ow_q));

  p_bad_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en_i && !ld_ok) |=>
      $stable(cwp_q) && $stable(cs_q) && $stable(cr_q) && $stable(ow_q));

  p_load_keeps_cwp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en_i |=> $stable(cwp_q) && !spill_q && !fill_q);

  p_one_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({spill_q, fill_q}));

endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter  int unsigned NWIN   = 8,
  parameter  int unsigned XLEN   = 32,
  localparam int unsigned CWP_W  = $clog2(NWIN),
  localparam int unsigned CNT_W  = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       rd_a_idx,
  output logic [XLEN-1:0]  rd_a_data,
  input  logic [4:0]       rd_b_idx,
  output logic [XLEN-1:0]  rd_b_data,
  input  logic             wr_en,
  input  logic [4:0]       wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             save_req,
  input  logic             restore_req,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_cansave,
  input  logic [CNT_W-1:0] ld_canrestore,
  input  logic [CNT_W-1:0] ld_otherwin,
  output logic [CWP_W-1:0] cwp,
  output logic [CNT_W-1:0] cansave,
  output logic [CNT_W-1:0] canrestore,
  output logic [CNT_W-1:0] otherwin,
  output logic             spill,
  output logic             fill
);
  import wrf_pkg::*;

  localparam int unsigned NPHYS  = NUM_GLOBALS + BANK_REGS * NWIN;
  localparam int unsigned PIDX_W = $clog2(NPHYS);
  localparam int unsigned NRD    = 2;
  localparam int unsigned NMAP   = NRD + 1;   // read ports then the write port

  logic                          rst_sync_n;
  logic [NMAP-1:0][LIDX_W-1:0]   lidx;
  logic [NMAP-1:0][PIDX_W-1:0]   pidx;
  logic [NRD-1:0][XLEN-1:0]      rdata;

  winreg_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  winreg_ctrl #(
    .NWIN  (NWIN),
    .CWP_W (CWP_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .save_i    (save_req),
    .restore_i (restore_req),
    .ld_en_i   (ld_en),
    .ld_cs_i   (ld_cansave),
    .ld_cr_i   (ld_canrestore),
    .ld_ow_i   (ld_otherwin),
    .cwp_o     (cwp),
    .cs_o      (cansave),
    .cr_o      (canrestore),
    .ow_o      (otherwin),
    .spill_o   (spill),
    .fill_o    (fill)
  );

  assign lidx[0] = rd_a_idx;
  assign lidx[1] = rd_b_idx;
  assign lidx[2] = wr_idx;

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    winreg_map #(
      .NWIN   (NWIN),
      .CWP_W  (CWP_W),
      .PIDX_W (PIDX_W)
    ) u_map (
      .cwp_i  (cwp),
      .lidx_i (lidx[m]),
      .pidx_o (pidx[m])
    );
  end

  winreg_array #(
    .XLEN   (XLEN),
    .NPHYS  (NPHYS),
    .PIDX_W (PIDX_W),
    .NRD    (NRD)
  ) u_array (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_pidx_i (pidx[NRD]),
    .wr_data_i (wr_data),
    .rd_pidx_i (pidx[NRD-1:0]),
    .rd_data_o (rdata)
  );

  assign rd_a_data = rdata[0];
  assign rd_b_data = rdata[1];

  p_zero_a_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_a_idx == 5'd0) |-> (rd_a_data == '0));

  p_zero_b_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_b_idx == 5'd0) |-> (rd_b_data == '0));

  p_fwd_a_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_idx != 5'd0 && wr_idx == rd_a_idx) |-> (rd_a_data == wr_data));

  p_fwd_b_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_idx != 5'd0 && wr_idx == rd_b_idx) |-> (rd_b_data == wr_data));

endmodule

// File: tb/sim_winreg_file.sv
module sim_winreg_file;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 22;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, save_req, restore_req, ld_en;
  logic [2:0]  ld_cansave, ld_canrestore, ld_otherwin;
  logic [2:0]  cwp, cansave, canrestore, otherwin;
  logic        spill, fill;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  winreg_file u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .save_req(save_req), .restore_req(restore_req),
    .ld_en(ld_en), .ld_cansave(ld_cansave),
    .ld_canrestore(ld_canrestore), .ld_otherwin(ld_otherwin),
    .cwp(cwp), .cansave(cansave), .canrestore(canrestore),
    .otherwin(otherwin), .spill(spill), .fill(fill)
  );

  // Nibbles: op(1 save,2 restore,3 both) ld lcs lcr low | cwp cs cr ow spill fill
  localparam logic [43:0] VEC [NVEC] = '{
    44'h2_0_0_0_0_0_6_0_0_0_1,
    44'h1_0_0_0_0_1_5_1_0_0_0,
    44'h1_0_0_0_0_2_4_2_0_0_0,
    44'h2_0_0_0_0_1_5_1_0_0_0,
    44'h3_0_0_0_0_2_4_2_0_0_0,
    44'h1_0_0_0_0_3_3_3_0_0_0,
    44'h1_0_0_0_0_4_2_4_0_0_0,
    44'h1_0_0_0_0_5_1_5_0_0_0,
    44'h1_0_0_0_0_6_0_6_0_0_0,
    44'h1_0_0_0_0_6_0_6_0_1_0,
    44'h0_1_1_2_4_6_0_6_0_0_0,
    44'h1_1_2_2_2_6_2_2_2_0_0,
    44'h2_0_0_0_0_5_3_1_2_0_0,
    44'h2_0_0_0_0_4_4_0_2_0_0,
    44'h2_0_0_0_0_4_4_0_2_0_1,
    44'h0_1_0_6_0_4_0_6_0_0_0,
    44'h2_0_0_0_0_3_1_5_0_0_0,
    44'h2_0_0_0_0_2_2_4_0_0_0,
    44'h2_0_0_0_0_1_3_3_0_0_0,
    44'h2_0_0_0_0_0_4_2_0_0_0,
    44'h2_0_0_0_0_7_5_1_0_0_0,
    44'h1_0_0_0_0_0_4_2_0_0_0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string vec_tag(input logic [43:0] v);
    if (v[3:0] != 4'd0) return "R8 refused restore";
    if (v[7:4] != 4'd0) return "R7 refused save";
    if (v[39:36] != 4'd0) begin
      if (v[19:16] == v[35:32] && v[15:12] == v[31:28] && v[11:8] == v[27:24])
        return "R10 valid load";
      return "R9 bad load dropped";
    end
    if (v[43:40] == 4'd3) return "R11 save over restore";
    if (v[43:40] == 4'd1) return "R5 save";
    return "R6 restore";
  endfunction

  task automatic idle_inputs();
    wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd_a_idx = '0; rd_b_idx = '0;
    save_req = 1'b0; restore_req = 1'b0;
    ld_en = 1'b0; ld_cansave = '0; ld_canrestore = '0; ld_otherwin = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_state(input string tag, input logic [2:0] ecwp, input logic [2:0] ecs,
                             input logic [2:0] ecr, input logic [2:0] eow,
                             input logic esp, input logic efl);
    chk({tag, " cwp"},        32'(cwp),        32'(ecwp));
    chk({tag, " cansave"},    32'(cansave),    32'(ecs));
    chk({tag, " canrestore"}, 32'(canrestore), 32'(ecr));
    chk({tag, " otherwin"},   32'(otherwin),   32'(eow));
    chk({tag, " spill"},      32'(spill),      32'(esp));
    chk({tag, " fill"},       32'(fill),       32'(efl));
  endtask

  task automatic write_reg(input logic [4:0] idx, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_a(input string tag, input logic [4:0] idx, input logic [31:0] exp);
    rd_a_idx = idx; #1;
    chk(tag, rd_a_data, exp);
  endtask

  task automatic read_b(input string tag, input logic [4:0] idx, input logic [31:0] exp);
    rd_b_idx = idx; #1;
    chk(tag, rd_b_data, exp);
  endtask

  task automatic do_save();
    save_req = 1'b1; @(negedge clk); save_req = 1'b0;
  endtask

  task automatic do_restore();
    restore_req = 1'b1; @(negedge clk); restore_req = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R13 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle_inputs();
    do_reset();

    // R13: reset state
    check_state("R13 reset", 3'd0, 3'd6, 3'd0, 3'd0, 1'b0, 1'b0);

    // Vector table: commands and counter loads
    for (int i = 0; i < NVEC; i++) begin
      save_req      = (VEC[i][43:40] == 4'd1) || (VEC[i][43:40] == 4'd3);
      restore_req   = (VEC[i][43:40] == 4'd2) || (VEC[i][43:40] == 4'd3);
      ld_en         = (VEC[i][39:36] != 4'd0);
      ld_cansave    = VEC[i][34:32];
      ld_canrestore = VEC[i][30:28];
      ld_otherwin   = VEC[i][26:24];
      @(negedge clk);
      idle_inputs();
      check_state(vec_tag(VEC[i]), VEC[i][22:20], VEC[i][18:16], VEC[i][14:12],
                  VEC[i][10:8], VEC[i][4], VEC[i][0]);
    end

    // R7/R8: flags last a single cycle
    @(negedge clk);
    chk("R7 spill one cycle", 32'(spill), 32'd0);
    chk("R8 fill one cycle",  32'(fill),  32'd0);

    // Directed register tests from a fresh reset
    do_reset();
    check_state("R13 second reset", 3'd0, 3'd6, 3'd0, 3'd0, 1'b0, 1'b0);

    // R12: same-cycle forwarding on both ports
    wr_en = 1'b1; wr_idx = 5'd9; wr_data = 32'h1234_0009;
    rd_a_idx = 5'd9; rd_b_idx = 5'd9; #1;
    chk("R12 forward port A", rd_a_data, 32'h1234_0009);
    chk("R12 forward port B", rd_b_data, 32'h1234_0009);
    @(negedge clk); wr_en = 1'b0;
    read_a("R12 value stored", 5'd9, 32'h1234_0009);

    // R2: register 0 write discarded, even in its own cycle
    wr_en = 1'b1; wr_idx = 5'd0; wr_data = 32'hDEAD_BEEF;
    rd_b_idx = 5'd0; #1;
    chk("R2 zero during write", rd_b_data, 32'h0);
    @(negedge clk); wr_en = 1'b0;
    read_a("R2 zero after write port A", 5'd0, 32'h0);
    read_b("R2 zero after write port B", 5'd0, 32'h0);

    // Window 0 contents
    write_reg(5'd5,  32'hA5A5_0005);   // global
    write_reg(5'd10, 32'h5555_000A);   // out 2
    write_reg(5'd17, 32'h7777_0011);   // local 1

    do_save();
    chk("R5 cwp after save", 32'(cwp), 32'd1);
    read_a("R1 global seen in window 1", 5'd5, 32'hA5A5_0005);
    read_b("R3 out2 of w0 is in2 of w1", 5'd26, 32'h5555_000A);
    write_reg(5'd17, 32'h8888_0011);   // local 1 of window 1
    write_reg(5'd26, 32'h6666_001A);   // in 2 of window 1

    do_restore();
    chk("R6 cwp after restore", 32'(cwp), 32'd0);
    read_a("R4 window 0 local kept", 5'd17, 32'h7777_0011);
    read_b("R3 in2 of w1 is out2 of w0", 5'd10, 32'h6666_001A);

    do_save();
    read_a("R4 window 1 local kept", 5'd17, 32'h8888_0011);
    do_restore();

    // R3 wrap: outs of the last window are ins of window 0
    ld_en = 1'b1; ld_cansave = 3'd0; ld_canrestore = 3'd6; ld_otherwin = 3'd0;
    @(negedge clk); idle_inputs();
    chk("R10 load canrestore", 32'(canrestore), 32'd6);
    do_restore();
    chk("R6 cwp wraps to 7", 32'(cwp), 32'd7);
    write_reg(5'd8, 32'h9999_0008);    // out 0 of window 7
    do_save();
    chk("R5 cwp wraps to 0", 32'(cwp), 32'd0);
    read_a("R3 out0 of w7 is in0 of w0", 5'd24, 32'h9999_0008);
    read_b("R1 global survives wrap", 5'd5, 32'hA5A5_0005);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule